// File: doc/BRIEF.md
# Row-Column Thermometer Decoder with Interpolation Select

This block drives the switch controls of a 16-cell segmented array laid out as a 4x4 grid. A 4-bit segment index k selects how many cells are fully on: cells 1 through k are enabled and every other cell is off. Alongside that thermometer vector, the block flags exactly one further cell, number k+1, as the cell that takes an externally generated interpolation input, so that an output can be blended between two adjacent segment levels.

Decoding is split in two. The upper index bits feed a row thermometer and the lower bits feed a column thermometer. Local logic in each cell combines the lines of its own row and column: XOR of two neighbouring row lines marks the active row, and XOR of two neighbouring column lines marks the active column. The cell at that crossing is the interpolation cell. Both output vectors are captured in one register stage on a shared clock edge, so every cell control changes at the same time.

Top module: `rc_thermo_decoder`

## Requirements
- R1: While `rst` is high at a rising clock edge, both `cell_on` and `cell_interp` are all zero after that edge.
- R2: A value of `seg_idx` sampled at a rising edge appears on both outputs just after that edge and not before; the outputs are registered with one cycle of latency.
- R3: Bit n of `cell_on` (n = 0..15, bit n controls cell n+1) is 1 exactly when n < k, where k is the registered `seg_idx`.
- R4: `cell_interp` has exactly one bit set outside reset, at bit position k (cell k+1).
- R5: For k = 0, `cell_on` is 16'h0000 and `cell_interp` is 16'h0001.
- R6: For k = 15, `cell_on` is 16'h7FFF and `cell_interp` is 16'h8000.
- R7: No bit is set in both `cell_on` and `cell_interp` in any cycle.
- R8: Cells are ordered row-major: bit n lies in row n/4 and column n%4, with `seg_idx[3:2]` naming the active row and `seg_idx[1:0]` the active column; cells in rows above the active row are all on, and in the active row only the columns left of the active column are on.
- R9: While `seg_idx` is held constant, both outputs stay unchanged from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all cell controls update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| seg_idx | input | 4 | Segment index k |
| cell_on | output | 16 | Registered thermometer enable, bit n for cell n+1 |
| cell_interp | output | 16 | Registered one-hot interpolation select |

## Verification
Both results are due one rising edge after the index is presented, so the bench changes `seg_idx` on a falling edge and compares outputs on the next falling edge, with exactly one rising edge in between. For the latency requirement it also samples a quarter period before that rising edge to confirm the previous result is still held. Reset is checked on the falling edge after a rising edge with `rst` high, and the hold check repeats the comparison over several falling edges with the index unchanged.

// File: rtl/rc_thermo_pkg.sv
package rc_thermo_pkg;
  localparam int DEF_ROW_BITS = 2;
  localparam int DEF_COL_BITS = 2;

  // Number of thermometer lines for a field of the given width:
  // one line per level plus a terminating line that is always low.
  function automatic int therm_lines(input int bits);
    return (1 << bits) + 1;
  endfunction
endpackage

// File: rtl/rc_therm_lines.sv
module rc_therm_lines #(
  parameter int BITS = 2,
  localparam int LEVELS = 1 << BITS
) (
  input  logic [BITS-1:0] val,
  output logic [LEVELS:0] lines
);
  // lines[j] is high when val >= j; lines[0] is always high and
  // lines[LEVELS] is always low, which closes the XOR chain.
  always_comb begin
    for (int j = 0; j <= LEVELS; j++) begin
      lines[j] = ({1'b0, val} >= (BITS+1)'(j));
    end
  end
endmodule

// File: rtl/rc_cell_logic.sv
module rc_cell_logic (
  input  logic row_lo,   // row line at this cell's row
  input  logic row_hi,   // row line one above
  input  logic col_lo,   // column line at this cell's column
  input  logic col_hi,   // column line one above
  output logic on_en,
  output logic interp_en
);
  logic row_act;
  logic col_act;

  always_comb begin
    row_act   = row_lo ^ row_hi;
    col_act   = col_lo ^ col_hi;
    // row fully passed, or active row with column passed
    on_en     = row_hi | (row_act & col_hi);
    interp_en = row_act & col_act;
  end
endmodule

// File: rtl/rc_thermo_decoder.sv
module rc_thermo_decoder
  import rc_thermo_pkg::*;
#(
  parameter int ROW_BITS = DEF_ROW_BITS,
  parameter int COL_BITS = DEF_COL_BITS,
  localparam int ROWS  = 1 << ROW_BITS,
  localparam int COLS  = 1 << COL_BITS,
  localparam int CELLS = ROWS * COLS,
  localparam int IDX_W = ROW_BITS + COL_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] seg_idx,
  output logic [CELLS-1:0] cell_on,
  output logic [CELLS-1:0] cell_interp
);
  logic [ROWS:0]      row_lines;
  logic [COLS:0]      col_lines;
  logic [CELLS-1:0]   on_d;
  logic [CELLS-1:0]   interp_d;

  rc_therm_lines #(.BITS(ROW_BITS)) u_row_dec (
    .val   (seg_idx[IDX_W-1:COL_BITS]),
    .lines (row_lines)
  );

  rc_therm_lines #(.BITS(COL_BITS)) u_col_dec (
    .val   (seg_idx[COL_BITS-1:0]),
    .lines (col_lines)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      rc_cell_logic u_cell (
        .row_lo    (row_lines[r]),
        .row_hi    (row_lines[r+1]),
        .col_lo    (col_lines[c]),
        .col_hi    (col_lines[c+1]),
        .on_en     (on_d[r*COLS + c]),
        .interp_en (interp_d[r*COLS + c])
      );
    end
  end

  // common output register: every cell control moves on one edge
  always_ff @(posedge clk) begin
    if (rst) begin
      cell_on     <= '0;
      cell_interp <= '0;
    end else begin
      cell_on     <= on_d;
      cell_interp <= interp_d;
    end
  end
endmodule

// File: rtl/rc_thermo_decoder_chk.sv
module rc_thermo_decoder_chk #(
  parameter int CELLS = 16,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [IDX_W-1:0] seg_idx,
  input logic [CELLS-1:0] cell_on,
  input logic [CELLS-1:0] cell_interp
);
  logic primed;

  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (cell_on == '0 && cell_interp == '0)); // R1

  AST_ON_COUNT: assert property (@(posedge clk) disable iff (rst)
    primed |-> ($countones(cell_on) == int'($past(seg_idx)))); // R2

  AST_THERMO_SHAPE: assert property (@(posedge clk) disable iff (rst)
    primed |-> (cell_interp == (~cell_on & {cell_on[CELLS-2:0], 1'b1}))); // R3

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
    primed |-> $onehot(cell_interp)); // R4

  AST_SELECT_AT_IDX: assert property (@(posedge clk) disable iff (rst)
    primed |-> cell_interp[$past(seg_idx)]); // R4

  AST_NO_CLASH: assert property (@(posedge clk) disable iff (rst)
    (cell_on & cell_interp) == '0); // R7

  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (rst)
    (primed && $stable(seg_idx)) |=> ($stable(cell_on) && $stable(cell_interp))); // R9
endmodule

bind rc_thermo_decoder rc_thermo_decoder_chk #(.CELLS(CELLS), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .seg_idx     (seg_idx),
  .cell_on     (cell_on),
  .cell_interp (cell_interp)
);

// File: tb/rc_thermo_decoder_tb.sv
module rc_thermo_decoder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  seg_idx = '0;
  logic [15:0] cell_on;
  logic [15:0] cell_interp;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  rc_thermo_decoder u_dut (
    .clk         (clk),
    .rst         (rst),
    .seg_idx     (seg_idx),
    .cell_on     (cell_on),
    .cell_interp (cell_interp)
  );

  // {index, expected on-vector, expected select}
  localparam logic [35:0] VEC [16] = '{
    {4'd0,  16'h0000, 16'h0001}, {4'd1,  16'h0001, 16'h0002},
    {4'd2,  16'h0003, 16'h0004}, {4'd3,  16'h0007, 16'h0008},
    {4'd4,  16'h000F, 16'h0010}, {4'd5,  16'h001F, 16'h0020},
    {4'd6,  16'h003F, 16'h0040}, {4'd7,  16'h007F, 16'h0080},
    {4'd8,  16'h00FF, 16'h0100}, {4'd9,  16'h01FF, 16'h0200},
    {4'd10, 16'h03FF, 16'h0400}, {4'd11, 16'h07FF, 16'h0800},
    {4'd12, 16'h0FFF, 16'h1000}, {4'd13, 16'h1FFF, 16'h2000},
    {4'd14, 16'h3FFF, 16'h4000}, {4'd15, 16'h7FFF, 16'h8000}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] k);
    @(negedge clk);
    seg_idx = k;
    @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    rst = 1'b1;
    seg_idx = 4'd9;
    @(negedge clk);
    @(negedge clk);
    chk("R1 on after reset", cell_on, 16'h0000);
    chk("R1 interp after reset", cell_interp, 16'h0000);
    rst = 1'b0;

    // R3 R4 R8: table walk over all indices
    for (int i = 0; i < 16; i++) begin
      apply(VEC[i][35:32]);
      chk($sformatf("R3 on k=%0d", i), cell_on, VEC[i][31:16]);
      chk($sformatf("R4 interp k=%0d", i), cell_interp, VEC[i][15:0]);
      chk($sformatf("R7 overlap k=%0d", i), cell_on & cell_interp, 16'h0000);
    end

    // R8: scrambled order, expected computed from row and column fields
    for (int i = 0; i < 16; i++) begin
      logic [3:0]  k;
      logic [15:0] exp_on;
      k = 4'((i * 7 + 3) % 16);
      exp_on = '0;
      for (int n = 0; n < 16; n++)
        exp_on[n] = ((n / 4) < int'(k[3:2])) ||
                    (((n / 4) == int'(k[3:2])) && ((n % 4) < int'(k[1:0])));
      apply(k);
      chk($sformatf("R8 row-major on k=%0d", k), cell_on, exp_on);
      chk($sformatf("R8 row-major interp k=%0d", k), cell_interp, 16'(1) << k);
    end

    // R5 and R6: extremes
    apply(4'd0);
    chk("R5 on k=0", cell_on, 16'h0000);
    chk("R5 interp k=0", cell_interp, 16'h0001);
    apply(4'd15);
    chk("R6 on k=15", cell_on, 16'h7FFF);
    chk("R6 interp k=15", cell_interp, 16'h8000);

    // R2: result not visible before the edge, visible after it
    @(negedge clk);
    seg_idx = 4'd5;
    #5;
    chk("R2 on before edge", cell_on, 16'h7FFF);
    chk("R2 interp before edge", cell_interp, 16'h8000);
    @(negedge clk);
    chk("R2 on after edge", cell_on, 16'h001F);
    chk("R2 interp after edge", cell_interp, 16'h0020);

    // R9: hold steady
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R9 on held", cell_on, 16'h001F);
      chk("R9 interp held", cell_interp, 16'h0020);
    end

    // R1: reset in mid-operation, then recovery
    apply(4'd15);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 on mid reset", cell_on, 16'h0000);
    chk("R1 interp mid reset", cell_interp, 16'h0000);
    rst = 1'b0;
    @(negedge clk);
    chk("R6 on after reset release", cell_on, 16'h7FFF);
    chk("R6 interp after reset release", cell_interp, 16'h8000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule